// File: doc/BRIEF.md
# Virtual Interrupt Flag Control Unit

This unit decides the outcome of an interrupt-disable (CLI) or interrupt-enable (STI) instruction. Depending on the current privilege level, the I/O privilege level and a virtual-interrupt enable bit, the instruction does one of three things: it updates the real interrupt flag, it updates the virtual interrupt flag, or it raises a general-protection fault. Virtual mode applies when the enable bit is 1, the privilege level is 3 and the I/O privilege level is below 3. In that mode, an STI issued while a virtual interrupt is pending becomes a trap, so that a handler can service the deferred interrupt.

The unit also gates incoming interrupt vectors. Exceptions and NMI (vectors below 32) always pass. Maskable hardware vectors pass only when the real interrupt flag is set. A privileged software port loads the virtual and pending flags, which lets a handler record a deferred interrupt and later re-enable the application.

Top module: `vif_ctrl_unit`

## Requirements
- R1: After reset, flag_if, flag_vif, flag_vip and gp_fault are all 0.
- R2: In virtual mode (pvi_en=1, cpl=3, iopl<3), an instruction that does not fault sets flag_vif to insn_sti (1=STI, 0=CLI) at the next clock edge. flag_if and flag_vip are unchanged.
- R3: In virtual mode, STI with flag_vip=1 raises a fault and changes no flag.
- R4: Outside virtual mode, CLI or STI with cpl numerically greater than iopl raises a fault and changes no flag.
- R5: Outside virtual mode, with cpl less than or equal to iopl, CLI clears flag_if and STI sets it, for any iopl value. flag_vif and flag_vip are unchanged.
- R6: When cpl is not 3, flag_vip has no effect: an STI with flag_vip=1 does not fault and sets flag_if.
- R7: gp_fault is high for exactly the one cycle after the clock edge that samples a faulting instruction strobe.
- R8: With irq_vld=1, irq_take is 1 for a vector below 32 regardless of the flags. For a vector from 32 to 255 it equals flag_if, and flag_vif has no effect. irq_take is combinational and 0 when irq_vld=0.
- R9: sw_wr=1 loads flag_vif from sw_vif and flag_vip from sw_vip at the next edge, leaving flag_if unchanged. The write is ignored in a cycle where insn_vld=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld | input | 1 | CLI/STI instruction strobe |
| insn_sti | input | 1 | 1 = STI, 0 = CLI |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| pvi_en | input | 1 | Virtual-interrupt enable |
| irq_vld | input | 1 | Interrupt vector valid |
| irq_vec | input | 8 | Interrupt vector number |
| sw_wr | input | 1 | Software flag write strobe |
| sw_vif | input | 1 | Value written to flag_vif |
| sw_vip | input | 1 | Value written to flag_vip |
| flag_if | output | 1 | Real interrupt flag |
| flag_vif | output | 1 | Virtual interrupt flag |
| flag_vip | output | 1 | Virtual interrupt pending flag |
| gp_fault | output | 1 | General-protection fault pulse |
| irq_take | output | 1 | Interrupt accepted |

## Verification
The instruction table crosses privilege level, I/O privilege level, enable bit and instruction kind with chosen starting flag values. Each row therefore distinguishes a virtual update from a real update from a fault, and a pending flag that traps from one that is ignored. Starting flags are chosen opposite to the expected result, so that a wrong flag being written, or a flag changing on a fault, shows up. The interrupt tests use vectors on both sides of the 31/32 boundary and at 255, and set the virtual flag opposite to the real flag so that gating on the wrong flag is caught. Directed tests cover the width of the fault pulse and a software write that collides with an instruction.

// File: rtl/vif_pkg.sv
package vif_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_REAL  = 2'd1,
      ACT_VIRT  = 2'd2,
      ACT_FAULT = 2'd3
   } vif_act_e;
endpackage

// File: rtl/vif_mode_dec.sv
module vif_mode_dec
   import vif_pkg::*;
#(
   parameter int PL_W = 2
) (
   input  logic            insn_vld,
   input  logic            insn_sti,
   input  logic [PL_W-1:0] cpl,
   input  logic [PL_W-1:0] iopl,
   input  logic            pvi_en,
   input  logic            cur_vip,
   output vif_act_e        act
);
   localparam logic [PL_W-1:0] LEAST_PRIV = PL_W'((1 << PL_W) - 1);

   logic virt_mode;
   logic trap_pend;

   assign virt_mode = pvi_en && (cpl == LEAST_PRIV) && (iopl != LEAST_PRIV);
   assign trap_pend = insn_sti && cur_vip;

   always_comb begin
      act = ACT_NONE;
      if (insn_vld) begin
         if (virt_mode)
            act = trap_pend ? ACT_FAULT : ACT_VIRT;
         else if (cpl > iopl)
            act = ACT_FAULT;
         else
            act = ACT_REAL;
      end
   end
endmodule

// File: rtl/vif_flag_regs.sv
module vif_flag_regs
   import vif_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  vif_act_e act,
   input  logic     insn_sti,
   input  logic     sw_wr,
   input  logic     sw_vif,
   input  logic     sw_vip,
   output logic     if_q,
   output logic     vif_q,
   output logic     vip_q,
   output logic     fault_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if_q    <= 1'b0;
         vif_q   <= 1'b0;
         vip_q   <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= (act == ACT_FAULT);
         case (act)
            ACT_REAL: if_q  <= insn_sti;
            ACT_VIRT: vif_q <= insn_sti;
            ACT_NONE: begin
               if (sw_wr) begin
                  vif_q <= sw_vif;
                  vip_q <= sw_vip;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vif_irq_gate.sv
module vif_irq_gate #(
   parameter int VEC_W   = 8,
   parameter int NUM_EXC = 32
) (
   input  logic             irq_vld,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             flag_if,
   output logic             irq_take
);
   localparam bit EXC_POW2 = ((NUM_EXC & (NUM_EXC - 1)) == 0);
   localparam int EXC_W    = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1;

   logic is_exc;

   generate
      if (EXC_POW2) begin : g_shift
         assign is_exc = ((irq_vec >> EXC_W) == '0);
      end else begin : g_cmp
         assign is_exc = (irq_vec < VEC_W'(NUM_EXC));
      end
   endgenerate

   assign irq_take = irq_vld && (is_exc || flag_if);
endmodule

// File: rtl/vif_ctrl_unit.sv
module vif_ctrl_unit
   import vif_pkg::*;
#(
   parameter int PL_W    = 2,
   parameter int VEC_W   = 8,
   parameter int NUM_EXC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             insn_vld,
   input  logic             insn_sti,
   input  logic [PL_W-1:0]  cpl,
   input  logic [PL_W-1:0]  iopl,
   input  logic             pvi_en,
   input  logic             irq_vld,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             sw_wr,
   input  logic             sw_vif,
   input  logic             sw_vip,
   output logic             flag_if,
   output logic             flag_vif,
   output logic             flag_vip,
   output logic             gp_fault,
   output logic             irq_take
);
   initial begin
      assert (PL_W >= 1) else $error("PL_W must be at least 1");
      assert (NUM_EXC >= 1 && NUM_EXC < (1 << VEC_W))
         else $error("NUM_EXC must lie within the vector space");
   end

   vif_act_e act;

   vif_mode_dec #(.PL_W(PL_W)) i_dec (
      .insn_vld (insn_vld),
      .insn_sti (insn_sti),
      .cpl      (cpl),
      .iopl     (iopl),
      .pvi_en   (pvi_en),
      .cur_vip  (flag_vip),
      .act      (act)
   );

   vif_flag_regs i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .insn_sti (insn_sti),
      .sw_wr    (sw_wr),
      .sw_vif   (sw_vif),
      .sw_vip   (sw_vip),
      .if_q     (flag_if),
      .vif_q    (flag_vif),
      .vip_q    (flag_vip),
      .fault_q  (gp_fault)
   );

   vif_irq_gate #(.VEC_W(VEC_W), .NUM_EXC(NUM_EXC)) i_gate (
      .irq_vld  (irq_vld),
      .irq_vec  (irq_vec),
      .flag_if  (flag_if),
      .irq_take (irq_take)
   );
endmodule

// File: rtl/vif_ctrl_chk.sv
module vif_ctrl_chk #(
   parameter int PL_W    = 2,
   parameter int VEC_W   = 8,
   parameter int NUM_EXC = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_vld,
   input logic             insn_sti,
   input logic [PL_W-1:0]  cpl,
   input logic [PL_W-1:0]  iopl,
   input logic             pvi_en,
   input logic             irq_vld,
   input logic [VEC_W-1:0] irq_vec,
   input logic             sw_wr,
   input logic             sw_vif,
   input logic             sw_vip,
   input logic             flag_if,
   input logic             flag_vif,
   input logic             flag_vip,
   input logic             gp_fault,
   input logic             irq_take
);
   localparam logic [PL_W-1:0] TOP_PL = PL_W'((1 << PL_W) - 1);

   // R7
   fault_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |=> !gp_fault);

   // R7
   fault_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $past(insn_vld));

   // R4
   flags_hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> ($stable(flag_if) && $stable(flag_vif) && $stable(flag_vip)));

   // R2
   virt_keeps_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld && pvi_en && cpl == TOP_PL && iopl != TOP_PL) |=> $stable(flag_if));

   // R5
   real_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld && !pvi_en && cpl <= iopl) |=> (flag_if == $past(insn_sti) && !gp_fault));

   // R8
   masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vld && irq_vec >= VEC_W'(NUM_EXC) && !flag_if) |-> !irq_take);

   // R8
   exc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vld && irq_vec < VEC_W'(NUM_EXC)) |-> irq_take);

   // R9
   sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !insn_vld) |=> (flag_vif == $past(sw_vif) && flag_vip == $past(sw_vip)));
endmodule

bind vif_ctrl_unit vif_ctrl_chk #(.PL_W(PL_W), .VEC_W(VEC_W), .NUM_EXC(NUM_EXC)) i_chk (
   .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn_sti(insn_sti),
   .cpl(cpl), .iopl(iopl), .pvi_en(pvi_en), .irq_vld(irq_vld), .irq_vec(irq_vec),
   .sw_wr(sw_wr), .sw_vif(sw_vif), .sw_vip(sw_vip), .flag_if(flag_if),
   .flag_vif(flag_vif), .flag_vip(flag_vip), .gp_fault(gp_fault), .irq_take(irq_take)
);

// File: tb/test_vif_ctrl_unit.sv
module test_vif_ctrl_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [1:0] cpl;
      logic [1:0] iopl;
      logic       pvi;
      logic       sti;
      logic       pif;
      logic       pvif;
      logic       pvip;
      logic       eif;
      logic       evif;
      logic       evip;
      logic       ef;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{2'd3, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      '{2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd3, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
      '{2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
      '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       insn_vld = 1'b0, insn_sti = 1'b0, pvi_en = 1'b0;
   logic [1:0] cpl = 2'd0, iopl = 2'd0;
   logic       irq_vld = 1'b0;
   logic [7:0] irq_vec = 8'd0;
   logic       sw_wr = 1'b0, sw_vif = 1'b0, sw_vip = 1'b0;
   logic       flag_if, flag_vif, flag_vip, gp_fault, irq_take;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vif_ctrl_unit i_vif_ctrl_unit (
      .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn_sti(insn_sti),
      .cpl(cpl), .iopl(iopl), .pvi_en(pvi_en), .irq_vld(irq_vld), .irq_vec(irq_vec),
      .sw_wr(sw_wr), .sw_vif(sw_vif), .sw_vip(sw_vip), .flag_if(flag_if),
      .flag_vif(flag_vif), .flag_vip(flag_vip), .gp_fault(gp_fault), .irq_take(irq_take)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // drive at negedge, one posedge, back at negedge (registered results visible)
   task automatic do_insn(input logic [1:0] c, input logic [1:0] io, input logic pv, input logic s);
      cpl = c; iopl = io; pvi_en = pv; insn_sti = s; insn_vld = 1'b1;
      @(posedge clk); @(negedge clk);
      insn_vld = 1'b0;
   endtask

   task automatic do_sw(input logic v, input logic p);
      sw_vif = v; sw_vip = p; sw_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      sw_wr = 1'b0;
   endtask

   task automatic preset(input logic fi, input logic fv, input logic fp);
      do_insn(2'd0, 2'd3, 1'b0, fi);
      do_sw(fv, fp);
   endtask

   task automatic irq_chk(input string req, input logic [7:0] v, input logic exp);
      irq_vld = 1'b1; irq_vec = v;
      #1;
      check(req, $sformatf("irq_take vec %0d", v), irq_take, exp);
      irq_vld = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      string tag;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "flag_if", flag_if, 1'b0);
      check("R1", "flag_vif", flag_vif, 1'b0);
      check("R1", "flag_vip", flag_vip, 1'b0);
      check("R1", "gp_fault", gp_fault, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t t;
         t = TBL[i];
         preset(t.pif, t.pvif, t.pvip);
         do_insn(t.cpl, t.iopl, t.pvi, t.sti);
         if (t.ef && t.pvi && t.cpl == 2'd3 && t.iopl != 2'd3) tag = "R3";
         else if (t.ef) tag = "R4";
         else if (t.pvi && t.cpl == 2'd3 && t.iopl != 2'd3) tag = "R2";
         else if (t.cpl != 2'd3 && t.pvip && t.sti) tag = "R6";
         else tag = "R5";
         check(tag, $sformatf("row %0d flag_if", i), flag_if, t.eif);
         check(tag, $sformatf("row %0d flag_vif", i), flag_vif, t.evif);
         check(tag, $sformatf("row %0d flag_vip", i), flag_vip, t.evip);
         check(tag, $sformatf("row %0d gp_fault", i), gp_fault, t.ef);
      end

      // R7 fault pulse is exactly one cycle
      preset(1'b0, 1'b0, 1'b0);
      do_insn(2'd3, 2'd0, 1'b0, 1'b1);
      check("R7", "gp_fault first cycle", gp_fault, 1'b1);
      @(negedge clk);
      check("R7", "gp_fault second cycle", gp_fault, 1'b0);

      // R8 interrupt gating, VIF set opposite to IF
      preset(1'b0, 1'b1, 1'b0);
      irq_chk("R8", 8'd14, 1'b1);
      irq_chk("R8", 8'd31, 1'b1);
      irq_chk("R8", 8'd32, 1'b0);
      irq_chk("R8", 8'd255, 1'b0);
      preset(1'b1, 1'b0, 1'b0);
      irq_chk("R8", 8'd32, 1'b1);
      irq_chk("R8", 8'd255, 1'b1);
      irq_chk("R8", 8'd2, 1'b1);
      #1;
      check("R8", "irq_take idle", irq_take, 1'b0);

      // R9 software write loads VIF/VIP, IF untouched
      preset(1'b1, 1'b0, 1'b0);
      do_sw(1'b1, 1'b1);
      check("R9", "sw flag_vif", flag_vif, 1'b1);
      check("R9", "sw flag_vip", flag_vip, 1'b1);
      check("R9", "sw flag_if", flag_if, 1'b1);
      // R9 write colliding with an instruction is ignored
      sw_vif = 1'b0; sw_vip = 1'b0; sw_wr = 1'b1;
      do_insn(2'd0, 2'd3, 1'b0, 1'b0);
      sw_wr = 1'b0;
      check("R9", "collide flag_vif", flag_vif, 1'b1);
      check("R9", "collide flag_vip", flag_vip, 1'b1);
      check("R5", "collide flag_if", flag_if, 1'b0);

      // R1 reset mid-run clears flags
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R1", "re-reset flag_vif", flag_vif, 1'b0);
      check("R1", "re-reset flag_vip", flag_vip, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule